// File: doc/BRIEF.md
# Run-Length Infrared Transmit Engine

This block turns a queue of run-length symbols into a modulated infrared drive signal. A host writes symbol bytes through a small register write port into a 32-deep queue. Each byte says whether the next stretch of time is a mark, with the carrier running, or a space, with the output quiet, and how many sample periods that stretch lasts. The engine drains the queue one symbol after another with no gap between them. When nothing is left it parks the output low.

The carrier has a programmable period and a programmable high time. The sample period is a programmable number of clock ticks. The host sees how many slots are occupied. It can take a level interrupt when the fill falls to one of four selectable low-water marks. It can empty the queue at any moment. A loopback switch steers the modulated signal to a separate test output instead of the drive pin.

Top module: `ir_rle_tx`

## Requirements
- R1: The queue holds up to 32 bytes, and `fill` always equals the number of bytes stored but not yet taken by the engine (0 to 32).
- R2: A write to address 0 while `fill` is 32 is discarded, and it sets `ovf_err`. `ovf_err` stays set until a queue clear.
- R3: A write to address 0 queues a symbol byte. If bit 7 is 0 the symbol is a mark; if bit 7 is 1 it is a space and both outputs stay low. Bits 6..0 hold n, and the symbol lasts n+1 sample periods. One sample period lasts D+1 clock cycles, where D is written at address 3 (reset value 3).
- R4: During a mark the carrier has a period of C+1 clocks and is high for the first W clocks of each period. If W > C it is high for the whole period. Address 2 holds W in bits 2..0 (reset 4) and C in bits 7..3 (reset 9). The carrier phase restarts at the first clock of every symbol.
- R5: Address 1 holds three control bits: bit 0 enables the interrupt, bits 2..1 are the threshold code, and bit 4 enables loopback. The threshold code maps 0 to 1 byte, 1 to 7 bytes, 2 to 17 bytes and 3 to 25 bytes, and its reset value is 2. `irq` is high exactly when the interrupt is enabled and `fill` is at or below the selected level.
- R6: A write to address 1 with bit 3 set empties the queue and aborts the symbol in progress. The next cycle shows `fill` = 0, `busy` = 0 and `ovf_err` = 0. The clear bit is not stored.
- R7: The engine takes the next byte in the same cycle the previous symbol ends. When the queue is empty at that point, `busy` falls and the outputs go low.
- R8: With loopback enabled the modulated signal appears on `loop_out` and `ir_out` stays low. With loopback disabled `loop_out` stays low.
- R9: After reset, `fill`, `busy`, `irq`, `ovf_err`, `ir_out` and `loop_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 symbol, 1 control, 2 carrier, 3 sample divisor |
| wr_data | input | 8 | Write data |
| ir_out | output | 1 | Modulated infrared drive |
| loop_out | output | 1 | Modulated signal in loopback mode |
| busy | output | 1 | A symbol is being played |
| fill | output | 6 | Occupied queue slots |
| irq | output | 1 | Low-data-level interrupt |
| ovf_err | output | 1 | Sticky overflow flag |

## Verification
The assertions assume that `wr_en`, `wr_addr` and `wr_data` carry known values on every clock after reset. They also assume that a clear and a symbol write can never fall in the same cycle, which the single address port guarantees. The bench changes the sample divisor and the carrier fields only while the engine is idle or between whole symbols. The reference model applies each register value from the cycle after its write, as the design does. All inputs are driven a quarter period after the rising edge, so every write falls in exactly one cycle.

// File: rtl/ir_rle_tx.sv
module ir_rle_tx #(
  parameter int DEPTH   = 32,
  parameter int DIV_W   = 8,
  parameter int PW_W    = 3,
  parameter int CFQ_W   = 5,
  parameter int PW_RST  = 4,
  parameter int CFQ_RST = 9,
  parameter int DIV_RST = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [1:0]                   wr_addr,
  input  logic [7:0]                   wr_data,
  output logic                         ir_out,
  output logic                         loop_out,
  output logic                         busy,
  output logic [$clog2(DEPTH+1)-1:0]   fill,
  output logic                         irq,
  output logic                         ovf_err
);
  localparam int AW    = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam int RUN_W = 7;

  logic [7:0]       mem [DEPTH];
  logic [AW-1:0]    wp_q, rp_q;
  logic [CNT_W-1:0] cnt_q, lvl_thr;
  logic             busy_q, lvl_q, err_q;
  logic [RUN_W-1:0] run_q;
  logic [DIV_W-1:0] samp_q, div_q;
  logic [CFQ_W-1:0] ph_q, cfq_q;
  logic [PW_W-1:0]  pw_q;
  logic             ien_q, lb_q;
  logic [1:0]       thr_q;

  logic wr_sym, wr_ctl, clr, full, push, pop, samp_hit, sym_end, mod;
  logic [7:0] head;

  assign wr_sym   = wr_en && (wr_addr == 2'd0);
  assign wr_ctl   = wr_en && (wr_addr == 2'd1);
  assign clr      = wr_ctl && wr_data[3];
  assign full     = (cnt_q == CNT_W'(DEPTH));
  assign push     = wr_sym && !full;
  assign samp_hit = busy_q && (samp_q >= div_q);
  assign sym_end  = samp_hit && (run_q == '0);
  assign pop      = (!busy_q || sym_end) && (cnt_q != '0);
  assign head     = mem[rp_q];

  always_comb begin
    case (thr_q)
      2'd0:    lvl_thr = CNT_W'(1);
      2'd1:    lvl_thr = CNT_W'(7);
      2'd2:    lvl_thr = CNT_W'(17);
      default: lvl_thr = CNT_W'(25);
    endcase
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q   <= '0;
      rp_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      lvl_q  <= 1'b0;
      run_q  <= '0;
      samp_q <= '0;
      ph_q   <= '0;
      err_q  <= 1'b0;
    end else if (clr) begin
      wp_q   <= '0;
      rp_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (wr_sym && full) err_q <= 1'b1;
      if (push) wp_q <= (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
      if (pop)  rp_q <= (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
      if (pop) begin
        busy_q <= 1'b1;
        lvl_q  <= head[7];
        run_q  <= head[RUN_W-1:0];
        samp_q <= '0;
        ph_q   <= '0;
      end else if (busy_q) begin
        samp_q <= samp_hit ? '0 : samp_q + 1'b1;
        ph_q   <= (ph_q == cfq_q) ? '0 : ph_q + 1'b1;
        if (samp_hit) begin
          if (run_q == '0) busy_q <= 1'b0;
          else             run_q  <= run_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q <= 1'b0;
      thr_q <= 2'd2;
      lb_q  <= 1'b0;
      pw_q  <= PW_W'(PW_RST);
      cfq_q <= CFQ_W'(CFQ_RST);
      div_q <= DIV_W'(DIV_RST);
    end else if (wr_en) begin
      case (wr_addr)
        2'd1: begin
          ien_q <= wr_data[0];
          thr_q <= wr_data[2:1];
          lb_q  <= wr_data[4];
        end
        2'd2: begin
          pw_q  <= wr_data[PW_W-1:0];
          cfq_q <= wr_data[7 -: CFQ_W];
        end
        2'd3: div_q <= wr_data[DIV_W-1:0];
        default: ;
      endcase
    end
  end

  assign mod      = busy_q && !lvl_q && (ph_q < CFQ_W'(pw_q));
  assign ir_out   = mod && !lb_q;
  assign loop_out = mod && lb_q;
  assign busy     = busy_q;
  assign fill     = cnt_q;
  assign irq      = ien_q && (cnt_q <= lvl_thr);
  assign ovf_err  = err_q;
endmodule

// File: rtl/ir_rle_tx_chk.sv
module ir_rle_tx_chk #(
  parameter int DEPTH = 32,
  parameter int CNT_W = $clog2(DEPTH+1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic [7:0]       wr_data,
  input logic [CNT_W-1:0] fill,
  input logic             busy,
  input logic             irq,
  input logic             ovf_err,
  input logic             ir_out,
  input logic             loop_out,
  input logic             lvl
);
  logic clr_w, sym_w;
  assign clr_w = wr_en && (wr_addr == 2'd1) && wr_data[3];
  assign sym_w = wr_en && (wr_addr == 2'd0);

  p_fill_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CNT_W'(DEPTH));

  p_full_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_w && fill == CNT_W'(DEPTH)) |=> ovf_err);

  p_err_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_err && !clr_w) |=> ovf_err);

  p_space_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && lvl) |-> (!ir_out && !loop_out));

  p_irq_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (fill <= CNT_W'(25)));

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_w |=> (fill == '0 && !busy && !ovf_err));

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ir_out && !loop_out));

  p_loop_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(ir_out && loop_out));
endmodule

bind ir_rle_tx ir_rle_tx_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .fill(fill), .busy(busy), .irq(irq), .ovf_err(ovf_err),
  .ir_out(ir_out), .loop_out(loop_out), .lvl(lvl_q)
);

// File: tb/sim_ir_rle_tx.sv
module sim_ir_rle_tx;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic ir_out, loop_out, busy, irq, ovf_err;
  logic [5:0] fill;

  ir_rle_tx u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ir_out(ir_out), .loop_out(loop_out), .busy(busy), .fill(fill),
    .irq(irq), .ovf_err(ovf_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  logic [7:0] q[$];
  int m_busy = 0, m_lvl = 0, m_run = 0, m_samp = 0, m_ph = 0, m_err = 0;
  int m_ien = 0, m_thr = 2, m_lb = 0, m_pw = 4, m_cfq = 9, m_div = 3;

  function automatic int lvl_of(int code);
    case (code)
      0: return 1;
      1: return 7;
      2: return 17;
      default: return 25;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      m_busy = 0; m_lvl = 0; m_run = 0; m_samp = 0; m_ph = 0; m_err = 0;
      m_ien = 0; m_thr = 2; m_lb = 0; m_pw = 4; m_cfq = 9; m_div = 3;
    end else begin
      bit hit, fin, take, clr, sym;
      int sz;
      logic [7:0] b;
      sz   = q.size();
      sym  = wr_en && wr_addr == 2'd0;
      clr  = wr_en && wr_addr == 2'd1 && wr_data[3];
      hit  = m_busy != 0 && m_samp >= m_div;
      fin  = hit && m_run == 0;
      take = (m_busy == 0 || fin) && sz != 0;
      if (clr) begin
        q.delete();
        m_busy = 0;
        m_err = 0;
      end else begin
        if (take) begin
          b = q.pop_front();
          m_busy = 1; m_lvl = b[7]; m_run = b[6:0]; m_samp = 0; m_ph = 0;
        end else if (m_busy != 0) begin
          m_samp = hit ? 0 : m_samp + 1;
          m_ph = (m_ph == m_cfq) ? 0 : m_ph + 1;
          if (hit) begin
            if (m_run == 0) m_busy = 0;
            else m_run = m_run - 1;
          end
        end
        if (sym) begin
          if (sz == 32) m_err = 1;
          else q.push_back(wr_data);
        end
      end
      if (wr_en && wr_addr == 2'd1) begin
        m_ien = wr_data[0]; m_thr = wr_data[2:1]; m_lb = wr_data[4];
      end
      if (wr_en && wr_addr == 2'd2) begin
        m_pw = wr_data[2:0]; m_cfq = wr_data[7:3];
      end
      if (wr_en && wr_addr == 2'd3) m_div = wr_data;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    int mod;
    mod = (m_busy != 0 && m_lvl == 0 && m_ph < m_pw) ? 1 : 0;
    vectors++;
    chk("R3/R4/R8 ir_out", ir_out, (m_lb == 0) ? mod : 0);
    chk("R8 loop_out", loop_out, (m_lb != 0) ? mod : 0);
    chk("R7 busy", busy, m_busy);
    chk("R1 fill", fill, q.size());
    chk("R5 irq", irq, (m_ien != 0 && q.size() <= lvl_of(m_thr)) ? 1 : 0);
    chk("R2 ovf_err", ovf_err, m_err);
  end

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk); #(CLK_PERIOD/4);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #(CLK_PERIOD/4);
    vectors++;
    chk("R9 reset fill", fill, 0);
    chk("R9 reset busy", busy, 0);
    chk("R9 reset irq", irq, 0);
    chk("R9 reset err", ovf_err, 0);
    chk("R9 reset ir_out", ir_out, 0);
    rst_n = 1'b1;
    idle(2);
    // R3 R4 default carrier and divisor
    wr(2'd0, 8'h02);
    idle(40);
    // R4 R5 new carrier, divisor, interrupt on
    wr(2'd3, 8'd1);
    wr(2'd2, {5'd5, 3'd2});
    wr(2'd1, 8'h05);
    wr(2'd0, 8'h03);
    wr(2'd0, 8'h82);
    wr(2'd0, 8'h00);
    idle(40);
    // R4 high time longer than period
    wr(2'd2, {5'd2, 3'd6});
    wr(2'd0, 8'h04);
    idle(30);
    // R8 loopback
    wr(2'd1, 8'h15);
    wr(2'd0, 8'h05);
    wr(2'd0, 8'h81);
    idle(30);
    wr(2'd1, 8'h05);
    // R1 R2 fill to full and overflow
    wr(2'd3, 8'd255);
    for (int i = 0; i < 35; i++) wr(2'd0, 8'h7f);
    wr(2'd1, 8'h01);
    wr(2'd1, 8'h03);
    wr(2'd1, 8'h07);
    idle(5);
    wr(2'd0, 8'h11);
    idle(3);
    // R6 clear while full and busy
    wr(2'd1, 8'h0d);
    idle(5);
    // R5 threshold sweep while draining
    wr(2'd3, 8'd0);
    wr(2'd2, {5'd3, 3'd2});
    wr(2'd1, 8'h03);
    for (int i = 0; i < 10; i++) wr(2'd0, 8'h85);
    idle(80);
    wr(2'd1, 8'h01);
    for (int i = 0; i < 3; i++) wr(2'd0, 8'h02);
    idle(20);
    wr(2'd1, 8'h07);
    for (int i = 0; i < 30; i++) wr(2'd0, (i % 2 == 0) ? 8'h81 : 8'h01);
    idle(120);
    // R6 clear during a long mark
    wr(2'd3, 8'd3);
    wr(2'd0, 8'h7f);
    wr(2'd0, 8'h10);
    idle(20);
    wr(2'd1, 8'h09);
    idle(10);
    // R7 back-to-back symbols after idle
    wr(2'd0, 8'h01);
    wr(2'd0, 8'h81);
    wr(2'd0, 8'h00);
    idle(40);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end
endmodule